// File: doc/BRIEF.md
# Raster-Op Rectangle Fill Engine

The engine accepts one rectangle fill command at a time and paints that rectangle into a linear framebuffer of 32-bit pixels. A command carries a source colour, the top-left corner (X, Y), a width, a height and a raster-operation code. For every pixel the engine combines the source colour with the pixel already in memory, using one of the sixteen two-operand logical functions, and writes the result back. The framebuffer base address and the byte distance between scanlines come in on plain control inputs. They must stay steady while a command runs.

Commands enter through a valid/ready handshake. The engine drops `cmd_ready` from the cycle after acceptance until it has finished, so a caller simply holds `cmd_valid` until it is taken. Memory traffic uses a single request channel with valid/ready. A request that is not taken holds its address, direction and data unchanged. Read data returns on a separate `mem_rvalid` strobe, any number of cycles after the read is taken. At most one read is outstanding, and the engine issues no further request until the data arrives. When a command completes, the engine raises `done` for one cycle. `err` rises with it when the code was invalid.

Top module: `rop_fill_engine`

## Requirements
- R1: `cmd_ready` is high only while the engine is idle, and a command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. The engine issues no memory request while idle and takes no new command before the current one ends with `done`.
- R2: For codes 0 to 15, each result bit is `code[{~s,~d}]`, where s is the colour bit and d is the old pixel bit. In order, the codes are: 0 zero, 1 s&d, 2 s&~d, 3 s, 4 ~s&d, 5 d, 6 s^d, 7 s|d, 8 ~(s|d), 9 ~s^d, 10 ~d, 11 s|~d, 12 ~s, 13 ~s|d, 14 ~(s&d), 15 all ones.
- R3: Pixel (x,y) sits at byte address base + y*stride + 4*x, truncated to the address width. Pixels are visited row by row, with x increasing fastest.
- R4: For any code that depends on the old pixel, a read of the pixel precedes its write. The written value combines the colour with the data returned by that read.
- R5: Codes 0, 3, 12 and 15 issue only writes, one per pixel, with no read.
- R6: A code of 16 or above causes no memory request. `done` and `err` are both high in the cycle after the command is taken.
- R7: A valid code with zero width or zero height causes no memory request. `done` is high, with `err` low, in the cycle after the command is taken.
- R8: `done` is a one-cycle pulse. It is high in the cycle after the last write of the rectangle is taken, and `err` is low.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted, and its address, direction and write data do not change.
- R10: After a read is taken, the engine issues no request until `mem_rvalid` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_base | input | ADDR_W | Byte address of pixel (0,0) |
| line_stride | input | ADDR_W | Bytes from one scanline to the next |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_color | input | 32 | Source colour |
| cmd_x | input | COORD_W | Left column |
| cmd_y | input | COORD_W | Top row |
| cmd_w | input | COORD_W | Width in pixels |
| cmd_h | input | COORD_W | Height in rows |
| cmd_rop | input | 5 | Raster-operation code (16 and above invalid) |
| mem_req_valid | output | 1 | Memory request asserted |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Byte address of the pixel |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Command finished (one cycle) |
| err | output | 1 | Finished command had an invalid code |

## Verification
The bench builds the engine with ADDR_W=20 and COORD_W=6. With these values the address arithmetic stays inside a small, sparse memory model. Rows and columns far from the origin remain cheap, so uneven strides can be tried at low cost. Memory ready follows a repeating pattern with gaps, and read data returns after one or two cycles. As a result, the hold rule under back-pressure and the wait for late read data are both exercised during ordinary fills. Every one of the sixteen codes runs against known old pixel contents. Invalid codes, zero-sized rectangles and multi-row rectangles with different strides cover the boundary cases.

// File: rtl/rop_fill_pkg.sv
package rop_fill_pkg;
  localparam int PIX_W     = 32;
  localparam int PIX_BYTES = PIX_W / 8;
  localparam int PIX_SH    = $clog2(PIX_BYTES);
  localparam int ROP_W     = 5;
  localparam int NUM_ROPS  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_WR,
    ST_FIN
  } fill_state_e;

  // A function ignores the old pixel when flipping d leaves every entry unchanged.
  function automatic logic rop_needs_dst(input logic [3:0] code);
    return !((code[0] == code[1]) && (code[2] == code[3]));
  endfunction
endpackage

// File: rtl/rop_alu.sv
module rop_alu #(
  parameter int W = 32
) (
  input  logic [3:0]   code,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  output logic [W-1:0] res
);
  // Each code is a four-entry truth table indexed by the inverted operand bits.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign res[i] = code[{~src[i], ~dst[i]}];
  end
endmodule

// File: rtl/rect_walker.sv
module rect_walker
  import rop_fill_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  stride,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W-1:0] w,
  input  logic [COORD_W-1:0] h,
  output logic [ADDR_W-1:0]  addr,
  output logic               last
);
  logic [COORD_W-1:0] col, row, w_r, h_r;
  logic [ADDR_W-1:0]  row_addr, stride_r, start_addr;
  logic               row_end;

  assign start_addr = base + ADDR_W'(y) * stride + (ADDR_W'(x) << PIX_SH);
  assign row_end    = (col == w_r - COORD_W'(1));
  assign last       = row_end && (row == h_r - COORD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col      <= '0;
      row      <= '0;
      w_r      <= '0;
      h_r      <= '0;
      stride_r <= '0;
      row_addr <= '0;
      addr     <= '0;
    end else if (load) begin
      col      <= '0;
      row      <= '0;
      w_r      <= w;
      h_r      <= h;
      stride_r <= stride;
      row_addr <= start_addr;
      addr     <= start_addr;
    end else if (step) begin
      if (row_end) begin
        col      <= '0;
        row      <= row + COORD_W'(1);
        row_addr <= row_addr + stride_r;
        addr     <= row_addr + stride_r;
      end else begin
        col  <= col + COORD_W'(1);
        addr <= addr + ADDR_W'(PIX_BYTES);
      end
    end
  end

  a_r3_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && !row_end |=> addr == $past(addr) + ADDR_W'(PIX_BYTES));
  a_r3_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && row_end |=> col == '0 && addr == $past(row_addr) + $past(stride_r));
endmodule

// File: rtl/rop_fill_engine.sv
module rop_fill_engine
  import rop_fill_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  fb_base,
  input  logic [ADDR_W-1:0]  line_stride,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [PIX_W-1:0]   cmd_color,
  input  logic [COORD_W-1:0] cmd_x,
  input  logic [COORD_W-1:0] cmd_y,
  input  logic [COORD_W-1:0] cmd_w,
  input  logic [COORD_W-1:0] cmd_h,
  input  logic [ROP_W-1:0]   cmd_rop,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [PIX_W-1:0]   mem_wdata,
  input  logic               mem_rvalid,
  input  logic [PIX_W-1:0]   mem_rdata,
  output logic               done,
  output logic               err
);
  fill_state_e      state, state_n;
  logic [PIX_W-1:0] color_r, result_r, alu_out, alu_dst;
  logic [3:0]       rop_r;
  logic             dep_r, err_r, cmd_fire, cmd_bad, cmd_empty, last, step;

  assign cmd_ready = (state == ST_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign cmd_bad   = (cmd_rop >= ROP_W'(NUM_ROPS));
  assign cmd_empty = (cmd_w == '0) || (cmd_h == '0);
  assign step      = (state == ST_WR) && mem_req_ready && !last;

  rect_walker #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .load(cmd_fire), .step(step),
    .base(fb_base), .stride(line_stride),
    .x(cmd_x), .y(cmd_y), .w(cmd_w), .h(cmd_h),
    .addr(mem_addr), .last(last)
  );

  // With no read the ALU sees a zero old pixel, which the independent codes ignore.
  assign alu_dst = (state == ST_WAIT) ? mem_rdata : '0;

  rop_alu #(.W(PIX_W)) u_alu (
    .code(rop_r), .src(color_r), .dst(alu_dst), .res(alu_out)
  );

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE: if (cmd_valid) begin
        if (cmd_bad || cmd_empty)          state_n = ST_FIN;
        else if (rop_needs_dst(cmd_rop[3:0])) state_n = ST_RD;
        else                               state_n = ST_WR;
      end
      ST_RD:   if (mem_req_ready) state_n = ST_WAIT;
      ST_WAIT: if (mem_rvalid)    state_n = ST_WR;
      ST_WR:   if (mem_req_ready) state_n = last ? ST_FIN : (dep_r ? ST_RD : ST_WR);
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      color_r  <= '0;
      rop_r    <= '0;
      dep_r    <= 1'b0;
      err_r    <= 1'b0;
      result_r <= '0;
    end else begin
      state <= state_n;
      if (cmd_fire) begin
        color_r <= cmd_color;
        rop_r   <= cmd_rop[3:0];
        dep_r   <= rop_needs_dst(cmd_rop[3:0]);
        err_r   <= cmd_bad;
      end
      if (state == ST_WAIT && mem_rvalid) result_r <= alu_out;
    end
  end

  assign mem_req_valid = (state == ST_RD) || (state == ST_WR);
  assign mem_we        = (state == ST_WR);
  assign mem_wdata     = dep_r ? result_r : alu_out;
  assign done          = (state == ST_FIN);
  assign err           = done && err_r;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid && !done);
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r5_no_read_indep: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_we |-> rop_needs_dst(rop_r));
  a_r6_invalid_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_bad |=> done && err && !mem_req_valid);
  a_r7_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !cmd_bad && cmd_empty |=> done && !err && !mem_req_valid);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_wait_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_we && mem_req_ready |=> !mem_req_valid);
endmodule

// File: tb/rop_fill_engine_bench.sv
module rop_fill_engine_bench;
  localparam int AW = 20;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] fb_base = '0, line_stride = '0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [31:0] cmd_color = '0;
  logic [CW-1:0] cmd_x = '0, cmd_y = '0, cmd_w = '0, cmd_h = '0;
  logic [4:0] cmd_rop = '0;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic done, err;

  always #4 clk = ~clk;

  rop_fill_engine #(.ADDR_W(AW), .COORD_W(CW)) u_rop_fill_engine (
    .clk(clk), .rst_n(rst_n), .fb_base(fb_base), .line_stride(line_stride),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_color(cmd_color),
    .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_w(cmd_w), .cmd_h(cmd_h), .cmd_rop(cmd_rop),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .err(err)
  );

  int tests = 0, fails = 0, cyc = 0;
  logic [31:0] phys[int];
  logic [31:0] refm[int];
  logic        exp_we[$];
  int          exp_addr[$];
  logic [31:0] exp_data[$];
  string       exp_tag[$];

  bit go_req = 0, busy = 0, just_issued = 0, done_due = 0, err_due = 0;
  bit hold_flag = 0, rd_flag = 0, hold_we = 0;
  int hold_addr = 0, rd_cnt = 0, rd_addr = 0;
  string done_tag = "R8";
  int q_x, q_y, q_w, q_h, q_rop, q_base, q_stride;
  logic [31:0] q_color;

  function automatic logic [31:0] seed(int a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction
  function automatic logic [31:0] peek_phys(int a);
    return phys.exists(a) ? phys[a] : seed(a);
  endfunction
  function automatic logic [31:0] peek_ref(int a);
    return refm.exists(a) ? refm[a] : seed(a);
  endfunction
  function automatic logic [31:0] ref_rop(int code, logic [31:0] s, logic [31:0] d);
    case (code)
      0: return 32'h0;
      1: return s & d;
      2: return s & ~d;
      3: return s;
      4: return ~s & d;
      5: return d;
      6: return s ^ d;
      7: return s | d;
      8: return ~(s | d);
      9: return ~s ^ d;
      10: return ~d;
      11: return s | ~d;
      12: return ~s;
      13: return ~s | d;
      14: return ~(s & d);
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
  function automatic bit ref_dep(int code);
    return !(code == 0 || code == 3 || code == 12 || code == 15);
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // Behavioural prediction of the request stream and final memory.
  task automatic predict();
    for (int r = 0; r < q_h; r++) begin
      for (int c = 0; c < q_w; c++) begin
        int a;
        logic [31:0] d, v;
        a = (q_base + (q_y + r) * q_stride + (q_x + c) * 4) & ((1 << AW) - 1);
        d = peek_ref(a);
        v = ref_rop(q_rop, q_color, d);
        if (ref_dep(q_rop)) begin
          exp_we.push_back(1'b0); exp_addr.push_back(a);
          exp_data.push_back('0); exp_tag.push_back("R4");
        end
        exp_we.push_back(1'b1); exp_addr.push_back(a);
        exp_data.push_back(v); exp_tag.push_back(ref_dep(q_rop) ? "R2" : "R5");
        refm[a] = v;
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      // R8 / R6 / R7: done and err timing
      if (done_due || done || err)
        check(done === done_due && err === err_due, done_tag, "done/err",
              {done, err}, {done_due, err_due});
      if (done) busy = 0;
      done_due = 0; err_due = 0;
      if (just_issued) begin
        check(cmd_ready === 1'b0, "R1", "ready dropped while busy", cmd_ready, 0);
        just_issued = 0;
      end
      if (cmd_valid) cmd_valid = 1'b0;
      // R10: no request while a read is outstanding
      if (mem_rvalid) rd_flag = 0;
      if (rd_flag && mem_req_valid)
        check(0, "R10", "request during read wait", mem_req_valid, 0);
      mem_rvalid = 1'b0;
      if (rd_cnt > 0) begin
        rd_cnt--;
        if (rd_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = peek_phys(rd_addr);
        end
      end
      // R9: stalled request must hold
      if (hold_flag) begin
        check(mem_req_valid === 1'b1 && int'(mem_addr) == hold_addr && mem_we === hold_we,
              "R9", "held request", {mem_req_valid, mem_we, mem_addr},
              {1'b1, hold_we, AW'(hold_addr)});
        hold_flag = 0;
      end
      mem_req_ready = (cyc % 3) != 1;
      if (mem_req_valid && !mem_req_ready) begin
        hold_flag = 1; hold_addr = int'(mem_addr); hold_we = mem_we;
      end
      if (mem_req_valid && mem_req_ready) begin
        if (exp_we.size() == 0) begin
          check(0, "R1", "unexpected request", mem_addr, 0);
        end else begin
          logic ew; int ea; logic [31:0] ed; string et;
          ew = exp_we.pop_front(); ea = exp_addr.pop_front();
          ed = exp_data.pop_front(); et = exp_tag.pop_front();
          check(mem_we === ew, et, "direction", mem_we, ew);
          check(int'(mem_addr) == ea, "R3", "address", mem_addr, ea);
          if (ew) begin
            check(mem_wdata === ed, et, "write data", mem_wdata, ed);
            phys[int'(mem_addr)] = mem_wdata;
          end else begin
            rd_cnt = 1 + (cyc % 2); rd_addr = int'(mem_addr); rd_flag = 1;
          end
          if (exp_we.size() == 0) begin done_due = 1; err_due = 0; done_tag = "R8"; end
        end
      end
      if (go_req && cmd_ready && !busy) begin
        cmd_valid = 1'b1; cmd_color = q_color; cmd_x = CW'(q_x); cmd_y = CW'(q_y);
        cmd_w = CW'(q_w); cmd_h = CW'(q_h); cmd_rop = 5'(q_rop);
        busy = 1; go_req = 0; just_issued = 1;
        if (q_rop >= 16) begin
          done_due = 1; err_due = 1; done_tag = "R6";
        end else if (q_w == 0 || q_h == 0) begin
          done_due = 1; err_due = 0; done_tag = "R7";
        end else begin
          predict();
        end
      end
    end
  end

  task automatic run(int x, int y, int w, int h, logic [31:0] color, int rop, int base, int stride);
    wait (!busy && !go_req);
    @(negedge clk);
    q_x = x; q_y = y; q_w = w; q_h = h; q_color = color; q_rop = rop;
    q_base = base; q_stride = stride;
    fb_base = AW'(base); line_stride = AW'(stride);
    go_req = 1;
    wait (go_req == 0);
    wait (busy == 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cmd_ready === 1'b1, "R1", "reset ready", cmd_ready, 1);
    check(mem_req_valid === 1'b0 && done === 1'b0 && err === 1'b0, "R1", "reset quiet",
          {mem_req_valid, done, err}, 0);
    rst_n = 1'b1;
    run(1, 2, 3, 2, 32'hF0F0_1234, 6, 32'h1000, 64);      // R2 R4 xor, two rows
    run(0, 0, 2, 2, 32'hCAFE_BABE, 3, 32'h2000, 128);     // R5 copy
    run(5, 1, 2, 1, 32'h0, 10, 32'h1000, 64);             // R4 invert
    run(1, 1, 4, 4, 32'h1111_1111, 16, 32'h1000, 64);     // R6
    run(1, 1, 4, 4, 32'h1111_1111, 31, 32'h1000, 64);     // R6
    run(1, 1, 0, 3, 32'h2222_2222, 7, 32'h1000, 64);      // R7
    run(1, 1, 3, 0, 32'h2222_2222, 3, 32'h1000, 64);      // R7
    for (int k = 0; k < 16; k++)                          // R2 every code
      run(2, 10 + k, 2, 1, 32'h0F0F_33CC ^ (k * 32'h0101_0101), k, 32'h4000, 72);
    run(7, 3, 1, 3, 32'h0, 15, 32'h8000, 200);            // R3 R5 set, odd stride
    run(62, 0, 1, 2, 32'hA5A5_A5A5, 14, 32'h9000, 256);   // R3 far column
    repeat (4) @(negedge clk);
    check(exp_we.size() == 0, "R8", "all requests seen", exp_we.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule